// File: doc/BRIEF.md
# Streaming matrix-vector multiplier

The block takes a signed matrix of ROWS by COLS elements and a signed vector of COLS elements in a single wide input beat. It returns the product vector of ROWS elements in a single wide output beat. Both sides follow the AXI4-Stream valid/ready handshake. No tlast or sideband signals are carried.

Inside, every row has its own set of element multipliers. These feed a binary adder tree with one register per tree level, so the arithmetic has a fixed latency. A valid bit travels beside the data through the same number of stages. The output side has a one-entry side register. If the consumer stalls while a result is being presented, that result is parked in the side register, and the whole pipeline then freezes until the side register empties. The input ready is therefore the inverse of one flip-flop. It never depends on the output ready within the same cycle.

Top module: `mvm_stream`

## Requirements
- R1: Each output element `y[r]` equals the signed sum over c of `k[r][c]*x[c]`. Element `k[r][c]` sits at bits `(r*COLS+c)*KW +: KW` of `s_kmat`, `x[c]` at `c*XW +: XW` of `s_xvec`, and `y[r]` at `r*YW +: YW` of `m_yvec`; all are two's complement.
- R2: With `m_ready` held high, a beat whose input handshake happens at one clock edge has its output handshake exactly DEPTH edges later. DEPTH is ceil(log2(COLS)), and at least 1.
- R3: `s_ready` is driven from a register only: changing `m_ready` between clock edges never changes `s_ready`.
- R4: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_yvec` stays unchanged on the following cycle.
- R5: Under arbitrary toggling of `s_valid` and `m_ready`, every accepted beat leaves exactly once, in acceptance order. A result presented while `m_ready` is low is parked, not dropped.
- R6: After reset, `s_ready` is low in a cycle exactly when the previous cycle had `m_valid` high and `m_ready` low; while it is low, no stage of the pipeline moves.
- R7: While `rst_n` (active low, synchronous) has been low for at least one clock edge, `m_valid` is low and `s_ready` is high, whatever was in flight before.
- R8: Output elements are YW = KW+XW+DEPTH bits wide, so that even all-extreme operands give the exact sum without wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Input beat accepted when high together with s_valid |
| s_kmat | input | ROWS*COLS*KW | Matrix, row-major, element 0 in the low bits |
| s_xvec | input | COLS*XW | Vector, element 0 in the low bits |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Consumer ready |
| m_yvec | output | ROWS*YW | Result vector, element 0 in the low bits |

## Verification
The bench uses an odd column count, so one node of the tree has no partner. A tree that dropped or doubled that leaf would give wrong sums on nearly every pattern of the value sweep. Results are compared in order while both handshake sides toggle at random. A skid stage that lost the parked beat, or sent it twice, would leave the expected queue out of step. Per cycle, the bench checks that `s_ready` does not move when `m_ready` moves, and that it follows the previous cycle's stall exactly. A combinational ready path, or a pipeline that kept moving during a stall, would break one of those checks. Extreme operands expose any result that is too narrow, and a reset with beats still stuck inside must leave nothing valid behind.

// File: rtl/mvm_pkg.sv
package mvm_pkg;

  // Number of registered adder levels for n leaves (at least one stage).
  function automatic int tree_depth(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/mvm_row_tree.sv
module mvm_row_tree
  import mvm_pkg::*;
#(
  parameter int COLS = 4,
  parameter int SW   = 18
) (
  input  logic                 clk,
  input  logic                 adv,
  input  logic signed [SW-1:0] leaf [COLS],
  output logic signed [SW-1:0] sum
);

  localparam int DEPTH = tree_depth(COLS);

  // Level l holds partial sums; slots past the live node count stay zero.
  logic signed [SW-1:0] lvl_q [DEPTH][COLS];

  // Pairwise reduction of one slot: two children, a lone child, or nothing.
  function automatic logic signed [SW-1:0] pair_sum(
    input logic signed [SW-1:0] v [COLS],
    input int                   j
  );
    if (2*j + 1 < COLS)  return v[2*j] + v[2*j+1];
    else if (2*j < COLS) return v[2*j];
    else                 return '0;
  endfunction

  always_ff @(posedge clk) begin
    if (adv) begin
      for (int l = 0; l < DEPTH; l++) begin
        for (int j = 0; j < COLS; j++) begin
          if (l == 0) lvl_q[0][j] <= pair_sum(leaf, j);
          else        lvl_q[l][j] <= pair_sum(lvl_q[l-1], j);
        end
      end
    end
  end

  assign sum = lvl_q[DEPTH-1][0];

endmodule

// File: rtl/mvm_core.sv
module mvm_core
  import mvm_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int KW   = 8,
  parameter int XW   = 8,
  localparam int DEPTH = tree_depth(COLS),
  localparam int YW    = KW + XW + DEPTH
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   adv,
  input  logic                   in_valid,
  input  logic [ROWS*COLS*KW-1:0] kmat,
  input  logic [COLS*XW-1:0]     xvec,
  output logic                   out_valid,
  output logic [ROWS*YW-1:0]     yvec
);

  localparam int PW = KW + XW;

  // Exact signed product, sign-extended to the result width.
  function automatic logic signed [YW-1:0] elem_prod(
    input logic signed [KW-1:0] a,
    input logic signed [XW-1:0] b
  );
    logic signed [PW-1:0] p;
    p = a * b;
    return YW'(p);
  endfunction

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic signed [YW-1:0] leaf [COLS];
    logic signed [YW-1:0] row_sum;
    for (genvar c = 0; c < COLS; c++) begin : g_col
      assign leaf[c] = elem_prod(kmat[(r*COLS+c)*KW +: KW], xvec[c*XW +: XW]);
    end
    mvm_row_tree #(.COLS(COLS), .SW(YW)) u_tree (
      .clk  (clk),
      .adv  (adv),
      .leaf (leaf),
      .sum  (row_sum)
    );
    assign yvec[r*YW +: YW] = row_sum;
  end

  // Valid bits shadow the tree levels.
  logic [DEPTH-1:0] vld_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else if (adv) begin
      vld_q[0] <= in_valid;
      for (int i = 1; i < DEPTH; i++) vld_q[i] <= vld_q[i-1];
    end
  end

  assign out_valid = vld_q[DEPTH-1];

  // R6: a frozen pipeline keeps its head result and its data.
  a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv && out_valid) |=> (out_valid && $stable(yvec)));

endmodule

// File: rtl/mvm_skid.sv
module mvm_skid #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         adv,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);

  logic         full_q;
  logic [W-1:0] side_q;

  // Named events for the checks below.
  logic park_ev, drain_ev;
  assign park_ev  = in_valid && !full_q && !m_ready;
  assign drain_ev = full_q && m_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)        full_q <= 1'b0;
    else if (park_ev)  full_q <= 1'b1;
    else if (drain_ev) full_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (park_ev) side_q <= in_data;
  end

  assign adv     = !full_q;
  assign m_valid = full_q || in_valid;
  assign m_data  = full_q ? side_q : in_data;

  // R4: a refused beat stays on the port unchanged.
  a_r4_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  // R5: a refused head beat is parked, not lost.
  a_r5_park_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    park_ev |=> (m_valid && m_data == $past(in_data)));

endmodule

// File: rtl/mvm_stream.sv
module mvm_stream
  import mvm_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  parameter int KW   = 8,
  parameter int XW   = 8,
  localparam int YW  = KW + XW + tree_depth(COLS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    s_valid,
  output logic                    s_ready,
  input  logic [ROWS*COLS*KW-1:0] s_kmat,
  input  logic [COLS*XW-1:0]      s_xvec,
  output logic                    m_valid,
  input  logic                    m_ready,
  output logic [ROWS*YW-1:0]      m_yvec
);

  logic                 adv;
  logic                 core_valid;
  logic [ROWS*YW-1:0]   core_y;

  mvm_core #(.ROWS(ROWS), .COLS(COLS), .KW(KW), .XW(XW)) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .adv       (adv),
    .in_valid  (s_valid),
    .kmat      (s_kmat),
    .xvec      (s_xvec),
    .out_valid (core_valid),
    .yvec      (core_y)
  );

  mvm_skid #(.W(ROWS*YW)) u_skid (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (core_valid),
    .in_data  (core_y),
    .adv      (adv),
    .m_valid  (m_valid),
    .m_ready  (m_ready),
    .m_data   (m_yvec)
  );

  assign s_ready = adv;

  // R3: input ready only drops after an output stall.
  a_r3_ready_drop_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(s_ready) |-> $past(m_valid && !m_ready));

  // R6: input ready only returns after the consumer took a beat.
  a_r6_ready_return_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s_ready) |-> $past(m_ready));

endmodule

// File: tb/tb_mvm_stream.sv
module tb_mvm_stream;
  localparam int ROWS = 3, COLS = 5, KW = 4, XW = 4;
  localparam int DEPTH = 3;
  localparam int YW = KW + XW + DEPTH;
  localparam int KB = ROWS*COLS*KW, XB = COLS*XW, YB = ROWS*YW;

  logic clk = 1'b0, rst_n = 1'b0, s_valid = 1'b0, m_ready = 1'b0;
  logic s_ready, m_valid;
  logic [KB-1:0] s_kmat = '0;
  logic [XB-1:0] s_xvec = '0;
  logic [YB-1:0] m_yvec;

  always #5 clk = ~clk;

  mvm_stream #(.ROWS(ROWS), .COLS(COLS), .KW(KW), .XW(XW)) dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_kmat(s_kmat), .s_xvec(s_xvec), .m_valid(m_valid),
    .m_ready(m_ready), .m_yvec(m_yvec)
  );

  int n_chk = 0, n_bad = 0, cyc = 0, n_in = 0, n_out = 0;
  int pv = 100, pr = 100;
  bit lat_on = 0, accepted = 0, hold_prev = 0, prev_stall = 0;
  logic [YB-1:0] prev_y;
  logic [KB-1:0] pk_q [$];
  logic [XB-1:0] px_q [$];
  logic [YB-1:0] exp_q [$];
  int acc_q [$];
  string data_tag = "R1";

  task automatic check(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] want);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h (cycle %0d)", tag, got, want, cyc);
    end
  endtask

  function automatic logic [YB-1:0] ref_y(input logic [KB-1:0] k, input logic [XB-1:0] x);
    logic [YB-1:0] y = '0;
    for (int r = 0; r < ROWS; r++) begin
      int acc = 0;
      for (int c = 0; c < COLS; c++)
        acc += int'($signed(k[(r*COLS+c)*KW +: KW])) * int'($signed(x[c*XW +: XW]));
      y[r*YW +: YW] = acc[YW-1:0];
    end
    return y;
  endfunction

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  // One cycle: drive at the falling edge, evaluate the handshakes of the next rising edge.
  task automatic step();
    logic sr_before;
    @(negedge clk);
    cyc++;
    if (accepted) begin s_valid = 1'b0; accepted = 0; end
    if (!s_valid && pk_q.size() > 0 && int'($urandom_range(99)) < pv) begin
      s_kmat = pk_q.pop_front();
      s_xvec = px_q.pop_front();
      s_valid = 1'b1;
    end
    sr_before = s_ready;
    m_ready = (int'($urandom_range(99)) < pr);
    #1;
    check(s_ready === sr_before, "R3 ready moved with m_ready", 64'(s_ready), 64'(sr_before));
    check(s_ready === !prev_stall, "R6 ready vs previous stall", 64'(s_ready), 64'(!prev_stall));
    if (hold_prev)
      check(m_valid === 1'b1 && m_yvec === prev_y, "R4 held beat", 64'(m_yvec), 64'(prev_y));
    if (m_valid && m_ready) begin
      n_out++;
      if (exp_q.size() == 0) begin
        check(0, "R5 extra output beat", 64'(m_yvec), 64'(0));
      end else begin
        logic [YB-1:0] want = exp_q.pop_front();
        int a = acc_q.pop_front();
        check(m_yvec === want, data_tag, 64'(m_yvec), 64'(want));
        if (lat_on) check(cyc - a == DEPTH, "R2 latency", 64'(cyc - a), 64'(DEPTH));
      end
    end
    hold_prev  = m_valid && !m_ready;
    prev_stall = m_valid && !m_ready;
    prev_y     = m_yvec;
    if (s_valid && s_ready) begin
      exp_q.push_back(ref_y(s_kmat, s_xvec));
      acc_q.push_back(cyc);
      accepted = 1;
      n_in++;
    end
  endtask

  task automatic drain();
    int g = 0;
    while ((pk_q.size() > 0 || s_valid || exp_q.size() > 0) && g < 20000) begin
      step();
      g++;
    end
    check(exp_q.size() == 0 && n_in == n_out, "R5 all beats delivered", 64'(n_out), 64'(n_in));
  endtask

  task automatic push_beat(input logic [KB-1:0] k, input logic [XB-1:0] x);
    pk_q.push_back(k);
    px_q.push_back(x);
  endtask

  initial begin
    #1500000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    report();
    $finish;
  end

  initial begin
    // R7: reset state
    repeat (3) @(negedge clk);
    check(m_valid === 1'b0, "R7 m_valid in reset", 64'(m_valid), 64'(0));
    check(s_ready === 1'b1, "R7 s_ready in reset", 64'(s_ready), 64'(1));
    rst_n = 1'b1;

    // Sweep: 256 structured patterns, consumer always ready, latency checked (R1, R2).
    for (int a = -8; a < 8; a++) begin
      for (int b = -8; b < 8; b++) begin
        logic [KB-1:0] k;
        logic [XB-1:0] x;
        for (int r = 0; r < ROWS; r++)
          for (int c = 0; c < COLS; c++)
            k[(r*COLS+c)*KW +: KW] = 4'(a + 3*r + c);
        for (int c = 0; c < COLS; c++) x[c*XW +: XW] = 4'(b - 2*c);
        push_beat(k, x);
      end
    end
    pv = 100; pr = 100; lat_on = 1; data_tag = "R1 sweep";
    drain();
    lat_on = 0;

    // Random operands with random valid and ready (R5).
    for (int i = 0; i < 300; i++) begin
      logic [KB-1:0] k;
      logic [XB-1:0] x;
      for (int w = 0; w < KB; w++) k[w] = 1'($urandom_range(1));
      for (int w = 0; w < XB; w++) x[w] = 1'($urandom_range(1));
      push_beat(k, x);
    end
    pv = 60; pr = 40; data_tag = "R5 random order";
    drain();

    // Extreme operands under heavy backpressure (R8).
    push_beat({(ROWS*COLS){4'h8}}, {COLS{4'h8}});
    push_beat({(ROWS*COLS){4'h8}}, {COLS{4'h7}});
    push_beat({(ROWS*COLS){4'h7}}, {COLS{4'h7}});
    push_beat({(ROWS*COLS){4'h7}}, {COLS{4'h8}});
    pv = 100; pr = 30; data_tag = "R8 extremes";
    drain();
    check(ref_y({(ROWS*COLS){4'h8}}, {COLS{4'h8}}) === {ROWS{11'd320}}, "R8 reference range",
          64'(ref_y({(ROWS*COLS){4'h8}}, {COLS{4'h8}})), 64'({ROWS{11'd320}}));

    // Reset with beats stuck inside (R7).
    for (int i = 0; i < 4; i++) push_beat(KB'(i * 77 + 5), XB'(i * 31 + 9));
    pv = 100; pr = 0; data_tag = "R1 pre-reset";
    repeat (10) step();
    @(negedge clk);
    rst_n = 1'b0; s_valid = 1'b0; m_ready = 1'b0;
    repeat (2) @(negedge clk);
    check(m_valid === 1'b0, "R7 m_valid after mid-run reset", 64'(m_valid), 64'(0));
    check(s_ready === 1'b1, "R7 s_ready after mid-run reset", 64'(s_ready), 64'(1));
    pk_q.delete(); px_q.delete(); exp_q.delete(); acc_q.delete();
    accepted = 0; hold_prev = 0; prev_stall = 0; n_in = 0; n_out = 0;
    rst_n = 1'b1;

    for (int i = 0; i < 6; i++) push_beat(KB'(i * 1234567 + 3), XB'(i * 4321 + 1));
    pv = 100; pr = 100; lat_on = 1; data_tag = "R1 post-reset";
    drain();

    report();
    $finish;
  end

endmodule